// File: doc/BRIEF.md
# Transmit Descriptor Ring Gatherer

This block services a transmit descriptor ring kept in host memory. Each descriptor is four 32-bit words: an ownership/status word, a control word holding two buffer sizes and a set of flags, and two address words. On a service request the block follows the ring from its current pointer. It collects the buffers of one frame from one or more descriptors and streams the frame out one byte at a time, with first and last markers and a valid/ready handshake. Once a descriptor's buffers are consumed, the block hands that descriptor back to the host by writing zero to its status word.

A descriptor that has neither segment flag set is a setup frame. It is never streamed. When its setup flag is set, a fixed number of words from its first buffer go out on a separate capture port. Before streaming anything, the block first checks that every descriptor of the frame is owned. A chain broken by a descriptor the host still holds is dropped, and nothing is output or written for it. Each frame, data or setup, ends with three steps: the first descriptor is released, a sticky completion flag is set, and an interrupt pulse is raised if the first descriptor asked for one. A single pass handles at most a fixed number of frames.

Top module: `txring_gather`

## Requirements
- R1: A pass starts on `poll` only when `tx_start` is 1 and `ring_base` is nonzero. Otherwise no memory access is made.
- R2: If the descriptor at the ring pointer has bit 31 of word 0 (ownership) clear, the pass makes exactly one read and then goes idle. It makes no write, streams nothing and raises no interrupt.
- R3: A first descriptor with both control bit 29 (first segment) and bit 30 (last segment) clear is a setup frame and streams nothing. If control bit 27 (setup) is set, the block reads SETUP_WORDS consecutive words starting at the address in word 2 and presents them in order on `setup_data`. Each word comes with a one-cycle `setup_valid`, and `setup_last` marks the final word.
- R4: Buffer 1 holds control bits 10:0 bytes and is read from the word-2 address. Buffer 2 holds bits 21:11 bytes and is read from the word-3 address, but only when that size is nonzero and control bit 24 (chained) is clear. Buffer addresses are word aligned, and bytes leave each word least significant byte first.
- R5: The next descriptor address is `ring_base` if control bit 25 (ring end) is set. Otherwise it is word 3 if bit 24 is set. Otherwise it is the current address plus 16.
- R6: Each descriptor after the first has zero written to its word 0 once its buffers have been streamed. The first descriptor's word 0 is written last, after the final byte.
- R7: Gathering ends at a descriptor with bit 30 or bit 27 set. If an unowned descriptor appears before that point, the frame is dropped: no byte is streamed, no write is made, the pass ends and the pointer stays on the frame's first descriptor.
- R8: A frame whose counted sizes add up to zero streams nothing, but its descriptors are still released.
- R9: Every completed frame sets `tx_stat`. `tx_stat` stays set until `stat_clr`, and a set wins over a clear. `tx_irq` pulses for one cycle only when control bit 31 of the frame's first descriptor is set.
- R10: One pass completes at most MAX_FRAMES frames. After that it goes idle with the pointer on the following descriptor.
- R11: `tx_first` marks the first byte of a frame and `tx_last` its last. While `tx_valid` is held against a low `tx_ready`, the byte and both markers stay unchanged, and no memory request is made while a byte is waiting.
- R12: While `tx_start` is 0, the ring pointer follows `ring_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | 32 | Ring base address |
| tx_start | input | 1 | Transmit enable |
| poll | input | 1 | Service request pulse |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data (always zero: ownership release) |
| mem_ack | input | 1 | Access completes in this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Byte present |
| tx_first | output | 1 | First byte of a frame |
| tx_last | output | 1 | Last byte of a frame |
| tx_ready | input | 1 | Sink accepts the byte |
| setup_data | output | 32 | Captured setup word |
| setup_valid | output | 1 | Setup word present (one cycle) |
| setup_last | output | 1 | Final setup word |
| tx_stat | output | 1 | Sticky frame-completed flag |
| tx_irq | output | 1 | Completion interrupt pulse |
| stat_clr | input | 1 | Clears `tx_stat` |

## Verification
The bench builds the block with MAX_FRAMES set to 3 and SETUP_WORDS set to 4. With a limit of three, a five-frame ring needs two passes, so the limit and the pointer hand-off between passes are exercised with only a few descriptors. With four setup words, the whole setup capture fits in a short run and can be compared word by word. The bench also uses random memory latency and random sink backpressure, so that holding a byte and stalling memory reads occur in many combinations.

// File: rtl/txring_gather.sv
module txring_gather #(
  parameter int MAX_FRAMES  = 4,
  parameter int SETUP_WORDS = 48
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ring_base,
  input  logic        tx_start,
  input  logic        poll,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  output logic        tx_first,
  output logic        tx_last,
  input  logic        tx_ready,
  output logic [31:0] setup_data,
  output logic        setup_valid,
  output logic        setup_last,
  output logic        tx_stat,
  output logic        tx_irq,
  input  logic        stat_clr
);
  localparam int FRW = $clog2(MAX_FRAMES + 1);
  localparam int SIW = $clog2(SETUP_WORDS + 1);
  localparam int B_OWN = 31;
  localparam int B_IC  = 31;
  localparam int B_LS  = 30;
  localparam int B_FS  = 29;
  localparam int B_SET = 27;
  localparam int B_TER = 25;
  localparam int B_TCH = 24;

  typedef enum logic [3:0] {
    S_IDLE, S_SC0, S_SC1, S_SC3, S_SU2, S_SUD,
    S_G1, S_G2, S_G3, S_GBUF, S_GEM, S_GDONE, S_GCLR, S_FIN
  } st_t;

  st_t         st;
  logic [31:0] ptr, cptr, w3r, baddr, wd;
  logic [10:0] sz1, sz2, bleft;
  logic        c_ic, c_ls, c_fs, c_set, c_ter, c_tch;
  logic        ic0, first_d, sent, bsel;
  logic [1:0]  bidx;
  logic [15:0] tot;
  logic [FRW-1:0] nfr;
  logic [SIW-1:0] sidx;
  logic        idle;

  function automatic logic [31:0] next_of(input logic [31:0] p, input logic ter,
                                          input logic tch, input logic [31:0] w3,
                                          input logic [31:0] base);
    return ter ? base : (tch ? w3 : p + 32'd16);
  endfunction

  wire        seg_end   = c_ls | c_set;
  wire        buf2_ok   = (sz2 != 11'd0) && !c_tch;
  wire [31:0] nx        = next_of(cptr, c_ter, c_tch, w3r, ring_base);
  wire        start_ok  = poll && tx_start && (ring_base != 32'd0);
  wire        last_frm  = (nfr == FRW'(MAX_FRAMES - 1));

  assign idle      = (st == S_IDLE);
  assign mem_wdata = 32'd0;
  assign tx_valid  = (st == S_GEM);
  assign tx_data   = wd[8*bidx +: 8];
  assign tx_first  = !sent;
  assign tx_last   = (tot == 16'd1);

  always_comb begin
    mem_req  = 1'b1;
    mem_we   = 1'b0;
    mem_addr = cptr;
    case (st)
      S_SC0:         mem_addr = cptr;
      S_SC1, S_G1:   mem_addr = cptr + 32'd4;
      S_SU2, S_G2:   mem_addr = cptr + 32'd8;
      S_SC3, S_G3:   mem_addr = cptr + 32'd12;
      S_SUD, S_GBUF: mem_addr = baddr;
      S_GCLR: begin mem_we = 1'b1; mem_addr = cptr; end
      S_FIN:  begin mem_we = 1'b1; mem_addr = ptr;  end
      default: mem_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ptr <= '0; cptr <= '0; w3r <= '0; baddr <= '0; wd <= '0;
      sz1 <= '0; sz2 <= '0; bleft <= '0;
      {c_ic, c_ls, c_fs, c_set, c_ter, c_tch} <= '0;
      ic0 <= 1'b0; first_d <= 1'b0; sent <= 1'b0; bsel <= 1'b0;
      bidx <= '0; tot <= '0; nfr <= '0; sidx <= '0;
      setup_data <= '0; setup_valid <= 1'b0; setup_last <= 1'b0;
      tx_stat <= 1'b0; tx_irq <= 1'b0;
    end else begin
      setup_valid <= 1'b0;
      tx_irq      <= 1'b0;
      if (st == S_FIN && mem_ack) tx_stat <= 1'b1;
      else if (stat_clr)          tx_stat <= 1'b0;

      case (st)
        S_IDLE: begin
          if (!tx_start) ptr <= ring_base;
          if (start_ok) begin
            cptr <= ptr; first_d <= 1'b1; tot <= '0; nfr <= '0;
            st <= S_SC0;
          end
        end
        S_SC0: if (mem_ack) st <= mem_rdata[B_OWN] ? S_SC1 : S_IDLE;
        S_SC1, S_G1: if (mem_ack) begin
          sz1 <= mem_rdata[10:0];
          sz2 <= mem_rdata[21:11];
          {c_ic, c_ls, c_fs, c_set, c_ter, c_tch} <=
            {mem_rdata[B_IC], mem_rdata[B_LS], mem_rdata[B_FS],
             mem_rdata[B_SET], mem_rdata[B_TER], mem_rdata[B_TCH]};
          st <= (st == S_SC1) ? S_SC3 : S_G2;
        end
        S_SC3: if (mem_ack) begin
          w3r <= mem_rdata;
          if (first_d) ic0 <= c_ic;
          if (first_d && !c_fs && !c_ls) begin
            st <= c_set ? S_SU2 : S_FIN;
          end else begin
            tot <= tot + {5'd0, sz1} + (c_tch ? 16'd0 : {5'd0, sz2});
            if (seg_end) begin
              cptr <= ptr; first_d <= 1'b1; sent <= 1'b0; st <= S_G1;
            end else begin
              cptr <= next_of(cptr, c_ter, c_tch, mem_rdata, ring_base);
              first_d <= 1'b0; st <= S_SC0;
            end
          end
        end
        S_SU2: if (mem_ack) begin
          baddr <= mem_rdata; sidx <= '0; st <= S_SUD;
        end
        S_SUD: if (mem_ack) begin
          setup_valid <= 1'b1;
          setup_data  <= mem_rdata;
          setup_last  <= (sidx == SIW'(SETUP_WORDS - 1));
          baddr <= baddr + 32'd4;
          sidx  <= sidx + 1'b1;
          if (sidx == SIW'(SETUP_WORDS - 1)) st <= S_FIN;
        end
        S_G2: if (mem_ack) begin baddr <= mem_rdata; st <= S_G3; end
        S_G3: if (mem_ack) begin
          w3r <= mem_rdata; bsel <= 1'b0;
          if (sz1 != 11'd0) begin
            bleft <= sz1; st <= S_GBUF;
          end else if (buf2_ok) begin
            baddr <= mem_rdata; bleft <= sz2; bsel <= 1'b1; st <= S_GBUF;
          end else begin
            st <= S_GDONE;
          end
        end
        S_GBUF: if (mem_ack) begin wd <= mem_rdata; bidx <= '0; st <= S_GEM; end
        S_GEM: if (tx_ready) begin
          sent  <= 1'b1;
          tot   <= tot - 16'd1;
          bleft <= bleft - 11'd1;
          bidx  <= bidx + 2'd1;
          if (bleft == 11'd1) begin
            if (!bsel && buf2_ok) begin
              baddr <= w3r; bleft <= sz2; bsel <= 1'b1; st <= S_GBUF;
            end else begin
              st <= S_GDONE;
            end
          end else if (bidx == 2'd3) begin
            baddr <= baddr + 32'd4; st <= S_GBUF;
          end
        end
        S_GDONE, S_GCLR: begin
          if (st == S_GDONE && !first_d) begin
            st <= S_GCLR;
          end else if (st == S_GDONE || mem_ack) begin
            if (seg_end) st <= S_FIN;
            else begin cptr <= nx; first_d <= 1'b0; st <= S_G1; end
          end
        end
        S_FIN: if (mem_ack) begin
          ptr <= nx;
          tx_irq <= ic0;
          if (last_frm) st <= S_IDLE;
          else begin
            nfr <= nfr + 1'b1; cptr <= nx; first_d <= 1'b1; tot <= '0;
            st <= S_SC0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module txring_gather_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ring_base,
  input logic        tx_start,
  input logic        idle,
  input logic        mem_req,
  input logic [7:0]  tx_data,
  input logic        tx_valid,
  input logic        tx_first,
  input logic        tx_last,
  input logic        tx_ready,
  input logic        setup_valid,
  input logic        tx_stat,
  input logic        tx_irq
);
  p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !(tx_start && ring_base != 32'd0)) |=> idle);

  p_setup_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    setup_valid |-> !tx_valid);

  p_irq_stat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> tx_stat);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) &&
                                 $stable(tx_first) && $stable(tx_last)));

  p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !mem_req);

  p_last_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |=> !tx_valid);

  p_first_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !tx_last) |=> !tx_first);
endmodule

bind txring_gather txring_gather_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .tx_start(tx_start),
  .idle(idle), .mem_req(mem_req), .tx_data(tx_data), .tx_valid(tx_valid),
  .tx_first(tx_first), .tx_last(tx_last), .tx_ready(tx_ready),
  .setup_valid(setup_valid), .tx_stat(tx_stat), .tx_irq(tx_irq)
);

// File: tb/txring_gather_tb_top.sv
`timescale 1ns/1ps
module txring_gather_tb_top;
  localparam int MAXF = 3;
  localparam int SW   = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] ring_base = 32'd0;
  logic tx_start = 1'b0, poll = 1'b0, stat_clr = 1'b0;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 32'd0;
  logic [7:0] tx_data;
  logic tx_valid, tx_first, tx_last, tx_ready = 1'b0;
  logic [31:0] setup_data;
  logic setup_valid, setup_last, tx_stat, tx_irq;

  always #2.5 clk = ~clk;

  txring_gather #(.MAX_FRAMES(MAXF), .SETUP_WORDS(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .tx_start(tx_start), .poll(poll),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_first(tx_first), .tx_last(tx_last),
    .tx_ready(tx_ready), .setup_data(setup_data), .setup_valid(setup_valid),
    .setup_last(setup_last), .tx_stat(tx_stat), .tx_irq(tx_irq), .stat_clr(stat_clr));

  logic [31:0] mem [0:1023];
  logic [31:0] mm  [0:1023];
  logic [9:0]  exp_b [$];
  logic [31:0] exp_w [$];
  logic [32:0] exp_s [$];
  int nchk = 0, nfail = 0;
  int exp_irq, obs_irq, obs_acc, exp_frames, wcnt = 0;
  logic [31:0] m_ptr = 32'd0, got_first, start_ptr;
  bit want_first = 0, rmode = 0, done = 0;
  logic [15:0] lf = 16'hace1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit ic, ls, fs, set, ter, tch,
                                     input int s2, input int s1);
    return {ic, ls, fs, 1'b0, set, 1'b0, ter, tch, 2'b00, s2[10:0], s1[10:0]};
  endfunction

  task automatic setdesc(input logic [31:0] a, input bit own, input logic [31:0] ctl,
                         input logic [31:0] w2, input logic [31:0] w3);
    mem[a[11:2]] = {own, 31'd0};     mm[a[11:2]] = {own, 31'd0};
    mem[a[11:2]+1] = ctl;            mm[a[11:2]+1] = ctl;
    mem[a[11:2]+2] = w2;             mm[a[11:2]+2] = w2;
    mem[a[11:2]+3] = w3;             mm[a[11:2]+3] = w3;
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mm[a[11:2]];
  endfunction

  function automatic logic [31:0] nxt_m(input logic [31:0] c, input logic [31:0] ctl);
    if (ctl[25]) return ring_base;
    if (ctl[24]) return rd(c + 12);
    return c + 16;
  endfunction

  function automatic logic [7:0] bytat(input logic [31:0] a, input int i);
    logic [31:0] w;
    w = mm[(a[11:2] + 10'(i / 4))];
    return w[8*(i%4) +: 8];
  endfunction

  task automatic model_pass();
    int nf;
    nf = 0;
    while (nf < MAXF) begin
      logic [31:0] d, ctl0, c, cc, nx;
      int tot, em, pos;
      bit ok;
      d = m_ptr;
      if (!rd(d)[31]) break;
      ctl0 = rd(d + 4);
      if (!ctl0[29] && !ctl0[30]) begin
        if (ctl0[27])
          for (int k = 0; k < SW; k++)
            exp_s.push_back({k == SW - 1, mm[rd(d + 8) >> 2 & 1023] == 0 ? mm[(rd(d + 8) >> 2) + k] : mm[(rd(d + 8) >> 2) + k]});
        nx = nxt_m(d, ctl0);
      end else begin
        c = d; tot = 0; ok = 1;
        forever begin
          if (!rd(c)[31]) begin ok = 0; break; end
          cc = rd(c + 4);
          tot += cc[10:0] + (cc[24] ? 0 : cc[21:11]);
          if (cc[30] || cc[27]) break;
          c = nxt_m(c, cc);
        end
        if (!ok) break;
        c = d; em = 0; pos = 0;
        forever begin
          cc = rd(c + 4);
          for (int i = 0; i < cc[10:0]; i++) begin
            exp_b.push_back({em == 0, em == tot - 1, bytat(rd(c + 8), i)}); em++;
          end
          if (cc[21:11] != 0 && !cc[24])
            for (int i = 0; i < cc[21:11]; i++) begin
              exp_b.push_back({em == 0, em == tot - 1, bytat(rd(c + 12), i)}); em++;
            end
          if (pos != 0) begin mm[c[11:2]] = 32'd0; exp_w.push_back(c); end
          if (cc[30] || cc[27]) begin nx = nxt_m(c, cc); break; end
          c = nxt_m(c, cc); pos++;
        end
      end
      mm[d[11:2]] = 32'd0; exp_w.push_back(d);
      if (ctl0[31]) exp_irq++;
      exp_frames++;
      m_ptr = nx;
      nf++;
    end
  endtask

  always @(negedge clk) begin
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    if (!rst_n) begin
      mem_ack = 1'b0; tx_ready = 1'b0;
    end else begin
      tx_ready = rmode ? (lf[0] | lf[1]) : 1'b1;
      if (tx_valid && tx_ready) begin
        if (exp_b.size() == 0) chk(0, "R4 unexpected stream byte", {22'd0, tx_first, tx_last, tx_data}, 0);
        else begin
          logic [9:0] e;
          e = exp_b.pop_front();
          chk({tx_first, tx_last, tx_data} == e, "R4 R11 stream byte/markers",
              {22'd0, tx_first, tx_last, tx_data}, {22'd0, e});
        end
      end
      if (tx_valid) chk(!mem_req, "R11 memory stalled under pending byte", {31'd0, mem_req}, 0);
      if (setup_valid) begin
        if (exp_s.size() == 0) chk(0, "R3 unexpected setup word", setup_data, 0);
        else begin
          logic [32:0] s;
          s = exp_s.pop_front();
          chk({setup_last, setup_data} == s, "R3 setup word", setup_data, s[31:0]);
        end
      end
      if (tx_irq) obs_irq++;
      mem_ack = 1'b0;
      if (mem_req) begin
        if (wcnt == 0) begin
          mem_ack = 1'b1; obs_acc++;
          if (mem_we) begin
            if (exp_w.size() == 0) chk(0, "R6 unexpected write", mem_addr, 0);
            else begin
              logic [31:0] wa;
              wa = exp_w.pop_front();
              chk(mem_addr == wa, "R6 release write order", mem_addr, wa);
            end
            chk(mem_wdata == 0, "R6 release value", mem_wdata, 0);
            mem[mem_addr[11:2]] = mem_wdata;
          end else begin
            mem_rdata = mem[mem_addr[11:2]];
            if (want_first) begin got_first = mem_addr; want_first = 0; end
          end
          wcnt = rmode ? int'(lf[3:2]) % 3 : 0;
        end else wcnt--;
      end
    end
  end

  task automatic run_pass(input bit active, input string tag);
    int q, g;
    exp_irq = 0; obs_irq = 0; obs_acc = 0; exp_frames = 0;
    start_ptr = m_ptr; got_first = 32'hffff_ffff;
    if (active) model_pass();
    want_first = 1;
    @(negedge clk); poll = 1'b1;
    @(negedge clk); poll = 1'b0;
    q = 0; g = 0;
    while (q < 40 && g < 20000) begin
      @(negedge clk);
      if (mem_req || tx_valid) q = 0; else q++;
      g++;
    end
    want_first = 0;
    chk(exp_b.size() == 0, {tag, " stream complete"}, exp_b.size(), 0);
    chk(exp_w.size() == 0, {tag, " releases complete"}, exp_w.size(), 0);
    chk(exp_s.size() == 0, {tag, " setup complete"}, exp_s.size(), 0);
    chk(obs_irq == exp_irq, {tag, " R9 irq count"}, obs_irq, exp_irq);
    if (exp_frames > 0) chk(tx_stat == 1'b1, {tag, " R9 status set"}, {31'd0, tx_stat}, 1);
    if (active) chk(got_first == start_ptr, {tag, " R5 R12 pass start address"}, got_first, start_ptr);
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 1024; i++) if (mem[i] !== mm[i]) bad++;
      chk(bad == 0, {tag, " memory image"}, bad, 0);
    end
    exp_b.delete(); exp_w.delete(); exp_s.delete();
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem[i] = (i >= 256) ? (i * 32'h0103_0507) ^ 32'h5a : 32'd0;
      mm[i] = mem[i];
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_valid && !mem_req && !setup_valid, "R11 reset quiet", {29'd0, tx_valid, mem_req, setup_valid}, 0);
    chk(!tx_stat && !tx_irq, "R9 reset status", {30'd0, tx_stat, tx_irq}, 0);

    // R1: disabled, then zero base
    ring_base = 32'h100; m_ptr = 32'h100;
    run_pass(0, "R1 start bit clear");
    chk(obs_acc == 0, "R1 no access without start", obs_acc, 0);
    tx_start = 1'b1; ring_base = 32'h0;
    run_pass(0, "R1 zero base");
    chk(obs_acc == 0, "R1 no access with zero base", obs_acc, 0);
    ring_base = 32'h100;

    // R2: first descriptor unowned
    setdesc(32'h100, 0, mk(1,1,1,0,0,0,0,5), 32'h400, 32'h0);
    run_pass(1, "R2 unowned");
    chk(obs_acc == 1, "R2 single read", obs_acc, 1);

    // main: two-buffer frame, setup frame, chained three-descriptor frame
    rmode = 1'b1;
    setdesc(32'h100, 1, mk(1,1,1,0,0,0,3,5), 32'h400, 32'h480);
    setdesc(32'h110, 1, mk(0,0,0,1,0,0,0,0), 32'h500, 32'h0);
    setdesc(32'h120, 1, mk(0,0,1,0,0,1,5,6), 32'h400, 32'h200);
    setdesc(32'h200, 1, mk(0,0,0,0,0,0,7,0), 32'h000, 32'h540);
    setdesc(32'h210, 1, mk(0,1,0,0,1,0,0,2), 32'h5a0, 32'h0);
    run_pass(1, "R3 R4 R5 main");
    chk(m_ptr == 32'h100, "R5 ring end wrap", m_ptr, 32'h100);

    // R7: unowned descriptor mid-chain, then completed chain
    setdesc(32'h100, 1, mk(1,0,1,0,0,0,0,4), 32'h420, 32'h0);
    setdesc(32'h110, 0, mk(0,1,0,0,0,0,0,3), 32'h440, 32'h0);
    run_pass(1, "R7 abort");
    mem[32'h110 >> 2] = 32'h8000_0000; mm[32'h110 >> 2] = 32'h8000_0000;
    run_pass(1, "R6 two-descriptor chain");

    // R8: zero-length frame and setup without capture
    setdesc(32'h120, 1, mk(1,1,1,0,0,0,0,0), 32'h400, 32'h400);
    setdesc(32'h130, 1, mk(1,0,0,0,0,0,0,0), 32'h500, 32'h0);
    run_pass(1, "R8 zero length");

    // R9: status clear
    @(negedge clk); stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0;
    chk(tx_stat == 1'b0, "R9 status cleared", {31'd0, tx_stat}, 0);

    // R10: five frames, limit three per pass
    setdesc(32'h140, 1, mk(1,1,1,0,0,0,0,1), 32'h400, 32'h0);
    setdesc(32'h150, 1, mk(0,1,1,0,0,0,0,4), 32'h410, 32'h0);
    setdesc(32'h160, 1, mk(1,1,1,0,0,0,2,3), 32'h420, 32'h430);
    setdesc(32'h170, 1, mk(0,1,1,0,0,0,0,8), 32'h440, 32'h0);
    setdesc(32'h180, 1, mk(1,1,1,0,1,0,0,2), 32'h460, 32'h0);
    run_pass(1, "R10 first pass");
    chk(m_ptr == 32'h170, "R10 pointer after limit", m_ptr, 32'h170);
    rmode = 1'b0;
    run_pass(1, "R10 second pass");

    // R12: pointer follows base while stopped
    tx_start = 1'b0;
    @(negedge clk); ring_base = 32'h300; m_ptr = 32'h300;
    setdesc(32'h300, 1, mk(1,1,1,0,1,0,0,9), 32'h480, 32'h0);
    @(negedge clk); @(negedge clk); tx_start = 1'b1;
    run_pass(1, "R12 new base");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule